// File: doc/BRIEF.md
# Grouped Prescaler and Per-Channel Tick Divider

This block turns one peripheral clock into five single-cycle count enables for a bank of timer channels. Two 8-bit prescalers run freely, each wrapping after P+1 clocks, where P is its programmed field. The two prescalers serve channel groups of unequal size: channels 0 and 1 share the first, and channels 2, 3 and 4 share the second. Behind its prescaler, each channel has a power-of-two divider. A 4-bit code selects the divider ratio, and the code is offset by a fixed base that is set by a parameter.

Software programs two configuration words through a simple write/read port. A change to a prescaler field takes effect only when that prescaler next wraps, so no period is ever cut short. Each channel's tick repeats every (P+1)·2^k clocks, where k is the channel's effective divider exponent.

Top module: `timer_tick_gen`

## Requirements
- R1: Channels 0 and 1 count from the prescaler field in word 0 bits [7:0]; channels 2, 3 and 4 count from the field in word 0 bits [15:8].
- R2: A prescaler field value P makes that prescaler wrap once every P+1 clock cycles.
- R3: Word 1 holds the selector for channel c in bits [4c+3:4c]. The channel's divider ratio is 2^(code+DIV_BASE).
- R4: With DIV_BASE=0, code 0 gives ratio 1. With DIV_BASE=1, code 0 gives ratio 2.
- R5: Any code with code+DIV_BASE above 4 gives ratio 16.
- R6: In steady state a channel's tick repeats every N=(P+1)·ratio cycles. When N>1 the tick is high for exactly one cycle; when N=1 it stays high.
- R7: Ticks are low while rst_ni is low. After reset is released, a channel's first tick appears after rising edge N, where N is its divided period at the reset configuration.
- R8: A new prescaler value is adopted only at that prescaler's next wrap. The period already in progress completes at the old length.
- R9: A write stores cfg_wdata_i into the word chosen by cfg_addr_i (0 or 1) on the clock edge. cfg_rdata_o returns the addressed word with all unused upper bits zero.
- R10: Both configuration words reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Word select: 0 prescalers, 1 divider selectors |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of addressed word |
| tick_o | output | 5 | Per-channel single-cycle count enables |

## Verification
The bench builds two copies side by side. One has DIV_BASE=0 and the other DIV_BASE=1, and both keep the default five channels, 8-bit prescalers and divide-by-16 cap. Driving both with the same configuration sweep covers both offsets and the saturation point for every channel. Every selector code from 0 to 7 is exercised, which reaches ratios 1 through 16 and codes well past the cap. Unequal prescaler pairs expose any channel wired to the wrong group. Short prescaler values keep each period under a hundred cycles, which makes it affordable to measure every channel's period exactly.

// File: rtl/tick_gen_pkg.sv
package tick_gen_pkg;

  // effective divider exponent: code plus base offset, clamped to cap
  function automatic int unsigned sat_log2(int unsigned code, int unsigned base,
                                           int unsigned cap);
    int unsigned sum;
    sum = code + base;
    return (sum > cap) ? cap : sum;
  endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic [1:0][PRE_W-1:0]        pre_o,
  output logic [NUM_CH-1:0][SEL_W-1:0] sel_o
);
  localparam int unsigned W0   = 2 * PRE_W;
  localparam int unsigned W1   = NUM_CH * SEL_W;
  localparam int unsigned WMAX = (W0 > W1) ? W0 : W1;

  logic [W0-1:0] word0_q;
  logic [W1-1:0] word1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word0_q <= '0;
      word1_q <= '0;
    end else if (we_i) begin
      if (!addr_i) word0_q <= wdata_i[W0-1:0];
      else         word1_q <= wdata_i[W1-1:0];
    end
  end

  assign rdata_o = addr_i ? DATA_W'(word1_q) : DATA_W'(word0_q);
  assign pre_o   = word0_q;
  assign sel_o   = word1_q;

  if (DATA_W > WMAX) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:WMAX];
  end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_val_i,
  output logic             wrap_o,
  output logic [PRE_W-1:0] act_o,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt_q, act_q;

  assign wrap_o = (cnt_q == act_q);

  // reload value only sampled at wrap: in-flight period keeps old length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      act_q <= pre_val_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div #(
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned LOG_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [LOG_W-1:0] log2_i,
  output logic             tick_o
);
  logic [MAX_LOG2-1:0] cnt_q, last;
  logic [MAX_LOG2:0]   span;
  logic                hit;

  always_comb begin
    span = (MAX_LOG2 + 1)'(1) << log2_i;
    last = MAX_LOG2'(span - 1'b1);
  end

  // >= so a smaller ratio written mid-count recovers at once
  assign hit = step_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= hit;
      if (hit)         cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned MAX_LOG2 = 4,
  parameter int unsigned DIV_BASE = 0,
  parameter int unsigned GRP0_CH  = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic [NUM_CH-1:0] tick_o
);
  import tick_gen_pkg::*;

  localparam int unsigned LOG_W = $clog2(MAX_LOG2 + 1);

  logic [1:0][PRE_W-1:0]        pre_vals, pre_act, pre_cnt;
  logic [1:0]                   pre_wrap;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_vals;
  logic [NUM_CH-1:0][LOG_W-1:0] chan_log2;

  tick_cfg_regs #(
    .NUM_CH(NUM_CH), .PRE_W(PRE_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .pre_o   (pre_vals),
    .sel_o   (sel_vals)
  );

  for (genvar g = 0; g < 2; g++) begin : g_pre
    tick_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pre_val_i (pre_vals[g]),
      .wrap_o    (pre_wrap[g]),
      .act_o     (pre_act[g]),
      .cnt_o     (pre_cnt[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;

    assign chan_log2[c] = LOG_W'(sat_log2(32'(sel_vals[c]), DIV_BASE, MAX_LOG2));

    tick_chan_div #(.MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (pre_wrap[GRP]),
      .log2_i (chan_log2[c]),
      .tick_o (tick_o[c])
    );
  end

endmodule

// File: rtl/tick_gen_chk.sv
module tick_gen_chk #(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned LOG_W    = 3,
  parameter int unsigned GRP0_CH  = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_we_i,
  input logic                         cfg_addr_i,
  input logic [2*PRE_W-1:0]           wr_lo_i,
  input logic [1:0][PRE_W-1:0]        pre_vals_i,
  input logic [1:0][PRE_W-1:0]        pre_act_i,
  input logic [1:0][PRE_W-1:0]        pre_cnt_i,
  input logic [1:0]                   pre_wrap_i,
  input logic [NUM_CH-1:0][LOG_W-1:0] chan_log2_i,
  input logic [NUM_CH-1:0]            tick_i
);

  // R9
  cfg_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_addr_i |=> pre_vals_i == $past(wr_lo_i));

  for (genvar g = 0; g < 2; g++) begin : g_pre_chk
    // R8
    reload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pre_wrap_i[g] |=> $stable(pre_act_i[g]));
    // R2
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_cnt_i[g] <= pre_act_i[g]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    localparam int unsigned GRP = (c < GRP0_CH) ? 0 : 1;
    // R1
    tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[c] |-> $past(pre_wrap_i[GRP]));
    // R6
    tick_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[c] && (chan_log2_i[c] != '0) |=> !tick_i[c]);
  end

endmodule

bind timer_tick_gen tick_gen_chk #(
  .NUM_CH(NUM_CH), .PRE_W(PRE_W), .LOG_W(LOG_W), .GRP0_CH(GRP0_CH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .wr_lo_i     (cfg_wdata_i[2*PRE_W-1:0]),
  .pre_vals_i  (pre_vals),
  .pre_act_i   (pre_act),
  .pre_cnt_i   (pre_cnt),
  .pre_wrap_i  (pre_wrap),
  .chan_log2_i (chan_log2),
  .tick_i      (tick_o)
);

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [NCH-1:0] tick_a, tick_b;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_tick_gen #(.DIV_BASE(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_a), .tick_o(tick_a));

  timer_tick_gen #(.DIV_BASE(1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_b), .tick_o(tick_b));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit tk(int inst, int ch);
    return inst == 0 ? tick_a[ch] : tick_b[ch];
  endfunction

  task automatic write_cfg(bit a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_tick(int inst, int ch);
    do @(negedge clk); while (!tk(inst, ch));
  endtask

  // cycles from the current tick to the next one
  task automatic interval(int inst, int ch, output int n, output bit first_low);
    n = 0;
    @(negedge clk); n++;
    first_low = !tk(inst, ch);
    while (!tk(inst, ch)) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    bit lo;
    // R7 R10: state under reset
    #1;
    check("R7 ticks low in reset (a)", tick_a, 0);
    check("R7 ticks low in reset (b)", tick_b, 0);
    addr = 1'b0; #1;
    check("R10 word0 reset", rdata_a, 0);
    addr = 1'b1; #1;
    check("R10 word1 reset", rdata_a, 0);
    addr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R7 R4: N=1 at base 0 ticks after edge 1; N=2 at base 1 after edge 2
    @(negedge clk);
    check("R7 R4 first tick edge1 base0", tick_a, 5'h1f);
    check("R7 R4 no tick edge1 base1", tick_b, 5'h00);
    @(negedge clk);
    check("R7 R4 first tick edge2 base1", tick_b, 5'h1f);

    // R9 readback with spare bits masked
    write_cfg(1'b0, 32'hFFFF_A5C3);
    write_cfg(1'b1, 32'hFFF1_2345);
    addr = 1'b0; #1;
    check("R9 word0 readback", rdata_a, 32'h0000_A5C3);
    addr = 1'b1; #1;
    check("R9 word1 readback", rdata_b, 32'h0001_2345);

    // R1 R2 R3 R4 R5 R6: sweep prescaler pairs and selector codes
    for (int pi = 0; pi < 4; pi++) begin
      int p0, p1;
      case (pi)
        0: begin p0 = 0; p1 = 0; end
        1: begin p0 = 2; p1 = 1; end
        2: begin p0 = 1; p1 = 4; end
        default: begin p0 = 5; p1 = 3; end
      endcase
      for (int it = 0; it < 4; it++) begin
        logic [31:0] w1;
        int code [NCH];
        w1 = '0;
        for (int c = 0; c < NCH; c++) begin
          code[c] = (it * 2 + c) % 8;
          w1[4*c +: 4] = 4'(code[c]);
        end
        write_cfg(1'b0, 32'((p1 << 8) | p0));
        write_cfg(1'b1, w1);
        for (int inst = 0; inst < 2; inst++) begin
          for (int c = 0; c < NCH; c++) begin
            int k, expn;
            string tag;
            k = code[c] + inst;
            if (k > 4) k = 4;
            expn = ((c < 2) ? p0 + 1 : p1 + 1) * (1 << k);
            if (code[c] + inst > 4) tag = "R5";
            else if (code[c] == 0) tag = "R4";
            else tag = "R3";
            wait_tick(inst, c);
            wait_tick(inst, c);
            interval(inst, c, n, lo);
            check($sformatf("R1 R2 R6 %s period inst%0d ch%0d", tag, inst, c), n, expn);
            if (expn > 1) check($sformatf("R6 width inst%0d ch%0d", inst, c), lo, 1);
          end
        end
      end
    end

    // R8: shrink prescaler 0 mid-period; old period completes first
    write_cfg(1'b1, 32'h0);
    write_cfg(1'b0, 32'h0000_0009);
    wait_tick(0, 0);
    wait_tick(0, 0);
    n = 0;
    @(negedge clk); n++;
    we = 1'b1; addr = 1'b0; wdata = 32'h0000_0001;
    @(negedge clk); n++;
    we = 1'b0;
    while (!tick_a[0]) begin
      @(negedge clk); n++;
    end
    check("R8 in-flight period keeps old length", n, 10);
    interval(0, 0, n, lo);
    check("R8 new length after wrap", n, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule